// File: doc/BRIEF.md
# Modem Status Tracker with Internal Loopback

This block keeps the eight-bit modem-status register of a serial port. The four upper bits show the present level of the clear-to-send, data-set-ready, ring and carrier-detect lines. The four lower bits are sticky change flags that record activity on those lines since software last read the register. In normal operation the external lines are resynchronised before use. In loopback operation the block ignores them and takes the line levels from the port's own modem-control outputs.

Each clock the block compares the incoming line levels with the levels it holds, sets the matching change flags and then replaces the held levels. A read strobe clears the change flags. A change found in the same clock as the read is still kept. The block gives the interrupt logic a pending flag, which is high while its enable is set and any change flag is set.

Top module: `modem_status_unit`

## Requirements
- R1: While the active-low reset is asserted, `statusReg` is 0x00 and `pending` is 0.
- R2: With `loopEn` high, the held levels taken at each clock edge come from `ctrlBits`: bit 1 drives status bit 4 (CTS), bit 0 drives status bit 5 (DSR), bit 2 drives status bit 6 (RI) and bit 3 drives status bit 7 (DCD).
- R3: With `loopEn` low, each external line passes through `SYNC_STAGES` flip-flops before the status register. A level change on `ctsIn`, `dsrIn`, `riIn` or `dcdIn` therefore appears in `statusReg` on the (`SYNC_STAGES`+1)-th rising edge after it is applied.
- R4: Status bit 0 (CTS change), bit 1 (DSR change) and bit 3 (DCD change) are set when the new level differs from the level held in bit 4, bit 5 and bit 7 respectively.
- R5: Status bit 2 (ring trailing edge) is set only when the new RI level is 0 and held bit 6 is 1. A 0-to-1 ring transition sets no flag.
- R6: Status bits 7:4 are overwritten with the new levels at every clock edge, after the comparison with the old held levels.
- R7: When `rdStrobe` is high at a rising edge, status bits 3:0 are cleared at that edge. `statusReg` shows the value that was present before the clear.
- R8: A change detected at the same edge as a read sets its flag after the clear, so the flag is 1 after that edge.
- R9: `pending` is 1 exactly when `intEnable` is 1 and at least one of status bits 3:0 is 1.
- R10: While `loopEn` is high, activity on the external lines has no effect on `statusReg` or `pending`.
- R11: Without a read, a set change flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlBits | input | 4 | Modem-control outputs: [0] DTR, [1] RTS, [2] OUT1, [3] OUT2 |
| loopEn | input | 1 | Selects the internal loopback source |
| ctsIn | input | 1 | External clear-to-send line |
| dsrIn | input | 1 | External data-set-ready line |
| riIn | input | 1 | External ring line |
| dcdIn | input | 1 | External carrier-detect line |
| rdStrobe | input | 1 | Register read; clears the change flags |
| intEnable | input | 1 | Modem-status interrupt enable |
| statusReg | output | 8 | [7] DCD, [6] RI, [5] DSR, [4] CTS, [3] DCD change, [2] RI trailing edge, [1] DSR change, [0] CTS change |
| pending | output | 1 | Modem-status interrupt pending |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 rather than the default of 2. This confirms that the external-line latency follows the parameter. It also lets a read strobe be placed exactly on the edge where a delayed line change reaches the register. The bench runs all sixteen control patterns in loopback while the external lines toggle. It then runs a long stretch of random line, read and enable activity, which produces simultaneous changes on several lines and reads that fall in the same cycle as a change.

// File: rtl/msu_pkg.sv
package msu_pkg;
  localparam int LINE_COUNT = 4;
  // line vector order: [0] CTS, [1] DSR, [2] RI, [3] DCD
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;
  // control bit positions
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_OUT1 = 2;
  localparam int CB_OUT2 = 3;

  typedef struct packed {
    logic                  clrFlags;
    logic [LINE_COUNT-1:0] evt;
  } msuStrobes_t;
endpackage

// File: rtl/msu_sync.sv
module msu_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[g] <= '0;
          else       chain[g] <= asyncIn;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[g] <= '0;
          else       chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/msu_ctrl.sv
module msu_ctrl
  import msu_pkg::*;
(
  input  logic [LINE_COUNT-1:0] syncLines,
  input  logic [3:0]            ctrlBits,
  input  logic                  loopEn,
  input  logic                  rdStrobe,
  input  logic [LINE_COUNT-1:0] heldLines,
  output logic [LINE_COUNT-1:0] newLines,
  output msuStrobes_t           strobes
);
  logic [LINE_COUNT-1:0] loopLines;

  always_comb begin
    loopLines[LN_CTS] = ctrlBits[CB_RTS];
    loopLines[LN_DSR] = ctrlBits[CB_DTR];
    loopLines[LN_RI]  = ctrlBits[CB_OUT1];
    loopLines[LN_DCD] = ctrlBits[CB_OUT2];
    newLines = loopEn ? loopLines : syncLines;
  end

  always_comb begin
    strobes.clrFlags    = rdStrobe;
    strobes.evt[LN_CTS] = newLines[LN_CTS] ^ heldLines[LN_CTS];
    strobes.evt[LN_DSR] = newLines[LN_DSR] ^ heldLines[LN_DSR];
    strobes.evt[LN_RI]  = heldLines[LN_RI] & ~newLines[LN_RI];
    strobes.evt[LN_DCD] = newLines[LN_DCD] ^ heldLines[LN_DCD];
  end
endmodule

// File: rtl/msu_dpath.sv
module msu_dpath
  import msu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINE_COUNT-1:0] newLines,
  input  msuStrobes_t           strobes,
  input  logic                  intEnable,
  output logic [2*LINE_COUNT-1:0] statusReg,
  output logic                  pending
);
  logic [LINE_COUNT-1:0] levelQ;
  logic [LINE_COUNT-1:0] flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
      flagQ  <= '0;
    end else begin
      levelQ <= newLines;
      flagQ  <= (strobes.clrFlags ? '0 : flagQ) | strobes.evt;
    end
  end

  assign statusReg = {levelQ, flagQ};
  assign pending   = intEnable & (|flagQ);
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] ctrlBits,
  input  logic       loopEn,
  input  logic       ctsIn,
  input  logic       dsrIn,
  input  logic       riIn,
  input  logic       dcdIn,
  input  logic       rdStrobe,
  input  logic       intEnable,
  output logic [7:0] statusReg,
  output logic       pending
);
  logic [LINE_COUNT-1:0] rawLines;
  logic [LINE_COUNT-1:0] syncLines;
  logic [LINE_COUNT-1:0] newLines;
  msuStrobes_t           strobes;

  assign rawLines = {dcdIn, riIn, dsrIn, ctsIn};

  msu_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINE_COUNT)) i_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawLines), .syncOut(syncLines)
  );

  msu_ctrl i_ctrl (
    .syncLines(syncLines), .ctrlBits(ctrlBits), .loopEn(loopEn),
    .rdStrobe(rdStrobe), .heldLines(statusReg[7:4]),
    .newLines(newLines), .strobes(strobes)
  );

  msu_dpath i_dpath (
    .clk(clk), .rstN(rstN), .newLines(newLines), .strobes(strobes),
    .intEnable(intEnable), .statusReg(statusReg), .pending(pending)
  );
endmodule

// File: rtl/msu_checker.sv
module msu_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] ctrlBits,
  input logic       loopEn,
  input logic       rdStrobe,
  input logic       intEnable,
  input logic [7:0] statusReg,
  input logic       pending
);
  // R2
  loop_cts_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |=> statusReg[4] == $past(ctrlBits[1]));
  // R2
  loop_dcd_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |=> statusReg[7] == $past(ctrlBits[3]));
  // R4
  cts_delta_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[4] != $past(statusReg[4]) |-> statusReg[0]);
  // R5
  ri_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusReg[6]) |-> statusReg[2]);
  // R5
  ri_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statusReg[6]) && $past(rdStrobe)) |-> !statusReg[2]);
  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobe && statusReg[1]) |=> statusReg[1]);
  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobe && pending && intEnable) |=> (pending || !intEnable));
endmodule

bind modem_status_unit msu_checker i_msu_checker (
  .clk(clk), .rstN(rstN), .ctrlBits(ctrlBits), .loopEn(loopEn),
  .rdStrobe(rdStrobe), .intEnable(intEnable), .statusReg(statusReg),
  .pending(pending)
);

// File: tb/test_modem_status_unit.sv
module test_modem_status_unit;
  localparam int STAGES = 3;

  logic clk = 0;
  logic rstN = 0;
  logic [3:0] ctrlBits = '0;
  logic loopEn = 0, ctsIn = 0, dsrIn = 0, riIn = 0, dcdIn = 0;
  logic rdStrobe = 0, intEnable = 0;
  logic [7:0] statusReg;
  logic pending;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  modem_status_unit #(.SYNC_STAGES(STAGES)) i_modem_status_unit (
    .clk(clk), .rstN(rstN), .ctrlBits(ctrlBits), .loopEn(loopEn),
    .ctsIn(ctsIn), .dsrIn(dsrIn), .riIn(riIn), .dcdIn(dcdIn),
    .rdStrobe(rdStrobe), .intEnable(intEnable),
    .statusReg(statusReg), .pending(pending)
  );

  // behavioural reference: delay queue of external samples, held levels, flags
  logic [3:0] extQ[$];
  logic [3:0] mLevel, mFlag;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extQ = {};
      for (int i = 0; i < STAGES; i++) extQ.push_back(4'b0);
      mLevel = 0; mFlag = 0;
    end else begin
      logic [3:0] ext, nl, ev;
      ext = extQ.pop_front();
      extQ.push_back({dcdIn, riIn, dsrIn, ctsIn});
      if (loopEn) nl = {ctrlBits[3], ctrlBits[2], ctrlBits[0], ctrlBits[1]};
      else nl = ext;
      ev[0] = nl[0] != mLevel[0];
      ev[1] = nl[1] != mLevel[1];
      ev[2] = mLevel[2] && !nl[2];
      ev[3] = nl[3] != mLevel[3];
      mFlag = (rdStrobe ? 4'b0 : mFlag) | ev;
      mLevel = nl;
    end
  end

  task automatic compare(string req);
    logic [7:0] expS;
    logic expP;
    expS = {mLevel, mFlag};
    expP = intEnable && (mFlag != 0);
    total++;
    if (statusReg !== expS || pending !== expP) begin
      bad++;
      $display("FAIL %s: status=%02h pending=%0b expected status=%02h pending=%0b",
               req, statusReg, pending, expS, expP);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!finished) compare(curReq);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setExt(logic [3:0] v);
    {dcdIn, riIn, dsrIn, ctsIn} = v;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cyc(3);
    compare("R1");
    rstN = 1;
    cyc(2);
    // R3 / R4: external levels appear after STAGES+1 edges
    curReq = "R3";
    setExt(4'b0001);
    cyc(1);
    setExt(4'b0000);
    cyc(STAGES + 2);
    curReq = "R4";
    setExt(4'b1010);
    cyc(STAGES + 3);
    // R7: read clears flags
    curReq = "R7";
    rdStrobe = 1; cyc(1); rdStrobe = 0; cyc(2);
    // R5: rising RI sets nothing, falling sets trailing flag
    curReq = "R5";
    setExt(4'b1110); cyc(STAGES + 3);
    rdStrobe = 1; cyc(1); rdStrobe = 0; cyc(1);
    setExt(4'b1010); cyc(STAGES + 3);
    // R11: flags stay without read
    curReq = "R11";
    cyc(6);
    // R8: event on the same edge as a read
    curReq = "R8";
    rdStrobe = 1; cyc(1); rdStrobe = 0; cyc(1);
    setExt(4'b1000);
    cyc(STAGES);
    rdStrobe = 1; cyc(1); rdStrobe = 0; cyc(3);
    // R9: pending follows enable and flags
    curReq = "R9";
    intEnable = 1; cyc(2);
    rdStrobe = 1; cyc(1); rdStrobe = 0; cyc(2);
    setExt(4'b0100); cyc(STAGES + 3);
    intEnable = 0; cyc(2); intEnable = 1; cyc(2);
    // R2 / R10: loopback over every control pattern, external lines toggling
    curReq = "R2";
    loopEn = 1;
    for (int k = 0; k < 16; k++) begin
      ctrlBits = k[3:0];
      setExt(~k[3:0]);
      cyc(2);
      rdStrobe = k[0]; cyc(1); rdStrobe = 0;
    end
    curReq = "R10";
    ctrlBits = 4'b0101;
    rdStrobe = 1; cyc(1); rdStrobe = 0; cyc(2);
    for (int k = 0; k < 20; k++) begin
      setExt(k[3:0]);
      cyc(1);
    end
    loopEn = 0;
    cyc(STAGES + 3);
    // R6: random stretch of lines, reads, enables and mode
    curReq = "R6";
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      setExt(r[3:0]);
      ctrlBits = r[7:4];
      rdStrobe = r[10:8] == 0;
      intEnable = r[11];
      loopEn = r[15:12] == 0;
      cyc(1);
    end
    rdStrobe = 0;
    cyc(3);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule